// File: doc/BRIEF.md
# TDM Time-Slot Routing Sequencer

This block decides, bit by bit, which serial channel owns the shared line of a time-division-multiplexed port. It serves up to four ports. Each port has two lanes, transmit and receive. Each lane walks its own list of 16-bit routing words in a shared table of 1024 words. The lower 512 words hold transmit lists and the upper 512 hold receive lists. A frame sync restarts a lane at the base of its list. Each word then owns the line for a whole number of bytes, and the lane reports a 3-bit channel code for every bit.

Software loads the table through a word write port. Through a small register port it sets each port's mode word and the global enable. All inputs are synchronous to the system clock `clk`. A lane sees a bit-clock edge by comparing the present level of the bit clock with the level it had one cycle earlier.

Top module: `tsr_router`

## Requirements
- R1: A routing word holds a last flag in bit 0, a repeat field in bits 4:2 and a channel select in bits 8:5. A lane keeps a word for (repeat+1)*8 bit clocks and then moves to the next word in its list.
- R2: The lane output codes are 0 for unused and 1 to 5 for channels one to five. Select value 9 gives code 1, 10 gives 2, 11 gives 3, 12 gives 4 and 1 gives 5. Every other select value gives 0.
- R3: When a word with the last flag set has run its full length, the lane outputs 0 on every bit until the next frame sync.
- R4: The mode word bits 15:12 (S) place a list at offset 32*S. The transmit list is in the lower half and the receive list is at the same offset in the upper half. Addresses wrap within their half. A lane that has used 128 words without finding a last flag outputs 0 until the next frame sync.
- R5: After reset every table word holds 0x0001 and every lane output is 0.
- R6: Register address 4 is the enable: bit p turns on port p. A port that is off outputs 0 on both lanes at once. Bits 7:4 have no effect.
- R7: When mode bit 5 is set, the frame sync is active low.
- R8: When mode bit 3 is set, the sync is sampled at the rising bit-clock edge and that bit is bit 0 of the frame. When bit 3 is clear, the sync is sampled at the falling edge and the next rising edge is bit 0.
- R9: When mode bit 6 is set, the port's transmit lane runs from the receive bit clock and receive sync.
- R10: A lane output changes only at the first system clock edge that sees the bit clock high after it was low. It holds its value between those edges.
- R11: A table write to the word a lane is holding does not change that lane's output for the rest of the frame. The new value applies from the next frame.
- R12: Register addresses 0 to 3 are the mode words of ports 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address: 0-3 mode words, 4 enable |
| regWdata | input | 16 | Register write data |
| tblWe | input | 1 | Table write strobe |
| tblAddr | input | 10 | Table word address |
| tblWdata | input | 16 | Table word data |
| rxBitClk | input | 4 | Receive bit clock, one per port |
| rxFrameSync | input | 4 | Receive frame sync, one per port |
| txBitClk | input | 4 | Transmit bit clock, one per port |
| txFrameSync | input | 4 | Transmit frame sync, one per port |
| rxChan | output | 12 | Receive channel code, 3 bits per port |
| txChan | output | 12 | Transmit channel code, 3 bits per port |

## Verification
Every lane is compared with an arithmetic walk of the table on every bit, and each lane is also checked just before each rising edge. The frames include the end of a 128-word list and a list that wraps inside its half. The test also gives a late sync under both sampling edges: a design that sampled on the wrong edge would start one bit early or late. An active-low port would start one bit off if its polarity were ignored. A transmit lane under loop mode would freeze if it kept its own idle clock. The test also rewrites the held word in the middle of a frame, which a design that fetches live would show at once. Finally it disables a port in the middle of a frame, where a design that held its last code would show a stale channel.

// File: rtl/tsr_pkg.sv
`timescale 1ns/1ps
package tsr_pkg;
  localparam int WORD_W   = 16;
  localparam int CHAN_W   = 3;
  localparam int LAST_BIT = 0;
  localparam int REP_LSB  = 2;
  localparam int REP_W    = 3;
  localparam int SEL_LSB  = 5;
  localparam int SEL_W    = 4;
  localparam int BYTE_SH  = 3;
  localparam logic [WORD_W-1:0] RESET_WORD = 16'h0001;

  typedef struct packed {
    logic run;
    logic bitTick;
    logic frameStart;
  } laneStrobe_t;

  typedef struct packed {
    logic [3:0] startField;
    logic       loopRx;
    logic       activeLow;
    logic       riseSample;
  } portMode_t;

  function automatic logic [CHAN_W-1:0] selToChan(input logic [SEL_W-1:0] sel);
    case (sel)
      4'h9:    return 3'd1;
      4'hA:    return 3'd2;
      4'hB:    return 3'd3;
      4'hC:    return 3'd4;
      4'h1:    return 3'd5;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/tsr_table.sv
`timescale 1ns/1ps
module tsr_table
  import tsr_pkg::*;
#(
  parameter int AW = 10,
  parameter int NUM_LANES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [AW-1:0]     rdAddr [NUM_LANES],
  output logic [WORD_W-1:0] rdData [NUM_LANES]
);
  localparam int DEPTH = 1 << AW;

  logic [WORD_W-1:0] words [DEPTH];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= RESET_WORD;
    end else if (wrEn) begin
      words[wrAddr] <= wrData;
    end
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_rd
    assign rdData[l] = words[rdAddr[l]];
  end

  // R11: a written word is what the lanes fetch afterwards
  a_r11_write_lands: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> words[$past(wrAddr)] == $past(wrData));
endmodule

// File: rtl/tsr_ctrl.sv
`timescale 1ns/1ps
module tsr_ctrl
  import tsr_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int REG_AW = 3,
  localparam int NUM_LANES = 2 * NUM_PORTS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 regWe,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic [WORD_W-1:0]    regWdata,
  input  logic [NUM_PORTS-1:0] rxBitClk,
  input  logic [NUM_PORTS-1:0] rxFrameSync,
  input  logic [NUM_PORTS-1:0] txBitClk,
  input  logic [NUM_PORTS-1:0] txFrameSync,
  output laneStrobe_t          strobe [NUM_LANES],
  output logic [3:0]           startField [NUM_PORTS]
);
  portMode_t              modeCfg [NUM_PORTS];
  logic [NUM_PORTS-1:0]   enReg;
  logic                   unusedWdata;

  assign unusedWdata = ^{regWdata[11:7], regWdata[4], regWdata[2:0]};

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int p = 0; p < NUM_PORTS; p++) modeCfg[p] <= '0;
      enReg <= '0;
    end else if (regWe) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (regAddr == REG_AW'(p)) begin
          modeCfg[p] <= '{startField: regWdata[15:12], loopRx: regWdata[6],
                          activeLow: regWdata[5], riseSample: regWdata[3]};
        end
      end
      if (regAddr == REG_AW'(NUM_PORTS)) enReg <= regWdata[NUM_PORTS-1:0];
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign startField[p] = modeCfg[p].startField;

    for (genvar d = 0; d < 2; d++) begin : g_dir
      localparam int L = 2 * p + d;
      logic bitClkSel, syncSel;
      logic clkPrev, syncSeen, pend;
      logic rise, fall, sampleEdge, syncAct, syncEvent;

      always_comb begin
        if (d == 1 || modeCfg[p].loopRx) begin
          bitClkSel = rxBitClk[p];
          syncSel   = rxFrameSync[p];
        end else begin
          bitClkSel = txBitClk[p];
          syncSel   = txFrameSync[p];
        end
      end

      assign rise       = bitClkSel & ~clkPrev;
      assign fall       = ~bitClkSel & clkPrev;
      assign sampleEdge = modeCfg[p].riseSample ? rise : fall;
      assign syncAct    = syncSel ^ modeCfg[p].activeLow;
      assign syncEvent  = sampleEdge & syncAct & ~syncSeen;

      always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
          clkPrev  <= 1'b0;
          syncSeen <= 1'b0;
          pend     <= 1'b0;
        end else begin
          clkPrev <= bitClkSel;
          if (sampleEdge) syncSeen <= syncAct;
          if (!enReg[p] || rise) pend <= 1'b0;
          else if (syncEvent)    pend <= 1'b1;
        end
      end

      assign strobe[L] = {enReg[p], enReg[p] & rise, enReg[p] & rise & (pend | syncEvent)};

      // R8: a sync caught on a falling edge arms the start of the next rising edge
      a_r8_fall_arms: assert property (@(posedge clk) disable iff (rst)
        (enReg[p] && !modeCfg[p].riseSample && fall && syncAct && !syncSeen) |=> pend);
    end
  end
endmodule

// File: rtl/tsr_walker.sv
`timescale 1ns/1ps
module tsr_walker
  import tsr_pkg::*;
#(
  parameter int AW = 10,
  parameter int REGION_DEPTH = 128,
  parameter int START_UNIT = 32,
  parameter bit IS_RX = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  laneStrobe_t       stb,
  input  logic [3:0]        startField,
  input  logic [WORD_W-1:0] rdData,
  output logic [AW-1:0]     rdAddr,
  output logic [CHAN_W-1:0] chanOut
);
  localparam int HALF_AW = AW - 1;
  localparam int PTR_W   = $clog2(REGION_DEPTH);
  localparam int UNIT_SH = $clog2(START_UNIT);
  localparam int BIT_W   = REP_W + BYTE_SH;
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(REGION_DEPTH - 1);

  logic                running;
  logic [PTR_W-1:0]    ptr;
  logic [BIT_W-1:0]    bitCnt;
  logic [WORD_W-1:0]   entry;

  logic [WORD_W-1:0]   cur;
  logic [PTR_W-1:0]    curPtr;
  logic [BIT_W-1:0]    curBit, lastBit;
  logic [HALF_AW-1:0]  baseOff, rdOff;
  logic                unusedEntry;

  assign baseOff = HALF_AW'(startField) << UNIT_SH;
  assign rdOff   = baseOff + (stb.frameStart ? HALF_AW'(0) : (HALF_AW'(ptr) + HALF_AW'(1)));
  assign rdAddr  = {IS_RX, rdOff};

  assign cur     = stb.frameStart ? rdData : entry;
  assign curPtr  = stb.frameStart ? '0 : ptr;
  assign curBit  = stb.frameStart ? '0 : bitCnt;
  assign lastBit = {cur[REP_LSB +: REP_W], {BYTE_SH{1'b1}}};
  assign unusedEntry = ^{cur[WORD_W-1:SEL_LSB+SEL_W], cur[1]};

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      running <= 1'b0;
      ptr     <= '0;
      bitCnt  <= '0;
      entry   <= '0;
      chanOut <= '0;
    end else if (!stb.run) begin
      running <= 1'b0;
      chanOut <= '0;
    end else if (stb.bitTick) begin
      if (stb.frameStart || running) begin
        chanOut <= selToChan(cur[SEL_LSB +: SEL_W]);
        if (curBit == lastBit) begin
          bitCnt <= '0;
          if (cur[LAST_BIT] || curPtr == PTR_MAX) begin
            running <= 1'b0;
          end else begin
            running <= 1'b1;
            ptr     <= curPtr + 1'b1;
            entry   <= rdData;
          end
        end else begin
          running <= 1'b1;
          bitCnt  <= curBit + 1'b1;
          ptr     <= curPtr;
          entry   <= cur;
        end
      end else begin
        chanOut <= '0;
      end
    end
  end

  // R6: a port that is off drives unused
  a_r6_idle_off: assert property (@(posedge clk) disable iff (rst)
    !stb.run |=> chanOut == '0);
  // R10: the code only moves on a bit tick
  a_r10_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    (stb.run && !stb.bitTick) |=> $stable(chanOut));
  // R1: the bit count never passes the length of the held word
  a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
    running |-> bitCnt <= {entry[REP_LSB +: REP_W], {BYTE_SH{1'b1}}});
  // R2: only the six legal codes appear
  a_r2_code_range: assert property (@(posedge clk) disable iff (rst)
    chanOut <= CHAN_W'(5));
  // R3: after the list has ended, ticks without a sync give unused
  a_r3_idle_after_last: assert property (@(posedge clk) disable iff (rst)
    (stb.run && stb.bitTick && !stb.frameStart && !running) |=> chanOut == '0);
endmodule

// File: rtl/tsr_router.sv
`timescale 1ns/1ps
module tsr_router
  import tsr_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int TABLE_AW = 10,
  parameter int REGION_DEPTH = 128,
  parameter int START_UNIT = 32,
  localparam int REG_AW = $clog2(NUM_PORTS + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        regWe,
  input  logic [REG_AW-1:0]           regAddr,
  input  logic [15:0]                 regWdata,
  input  logic                        tblWe,
  input  logic [TABLE_AW-1:0]         tblAddr,
  input  logic [15:0]                 tblWdata,
  input  logic [NUM_PORTS-1:0]        rxBitClk,
  input  logic [NUM_PORTS-1:0]        rxFrameSync,
  input  logic [NUM_PORTS-1:0]        txBitClk,
  input  logic [NUM_PORTS-1:0]        txFrameSync,
  output logic [NUM_PORTS*3-1:0]      rxChan,
  output logic [NUM_PORTS*3-1:0]      txChan
);
  localparam int NUM_LANES = 2 * NUM_PORTS;

  laneStrobe_t       strobe   [NUM_LANES];
  logic [3:0]        startFld [NUM_PORTS];
  logic [TABLE_AW-1:0] rdAddr [NUM_LANES];
  logic [WORD_W-1:0] rdData   [NUM_LANES];
  logic [CHAN_W-1:0] laneChan [NUM_LANES];

  tsr_ctrl #(.NUM_PORTS(NUM_PORTS), .REG_AW(REG_AW)) u_ctrl (
    .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .rxBitClk(rxBitClk), .rxFrameSync(rxFrameSync),
    .txBitClk(txBitClk), .txFrameSync(txFrameSync),
    .strobe(strobe), .startField(startFld)
  );

  tsr_table #(.AW(TABLE_AW), .NUM_LANES(NUM_LANES)) u_table (
    .clk(clk), .rst(rst), .wrEn(tblWe), .wrAddr(tblAddr), .wrData(tblWdata),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    tsr_walker #(
      .AW(TABLE_AW), .REGION_DEPTH(REGION_DEPTH),
      .START_UNIT(START_UNIT), .IS_RX((l % 2) == 1)
    ) u_walk (
      .clk(clk), .rst(rst), .stb(strobe[l]), .startField(startFld[l / 2]),
      .rdData(rdData[l]), .rdAddr(rdAddr[l]), .chanOut(laneChan[l])
    );
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_out
    assign txChan[p*CHAN_W +: CHAN_W] = laneChan[2*p];
    assign rxChan[p*CHAN_W +: CHAN_W] = laneChan[2*p+1];
  end
endmodule

// File: tb/sim_tsr_router.sv
`timescale 1ns/1ps
module sim_tsr_router;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic        tblWe = 1'b0;
  logic [9:0]  tblAddr = '0;
  logic [15:0] tblWdata = '0;
  logic [3:0]  rxBitClk = 4'hF, txBitClk = 4'hF;
  logic [3:0]  rxFrameSync = '0, txFrameSync = '0;
  logic [11:0] rxChan, txChan;

  tsr_router u0 (
    .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .tblWe(tblWe), .tblAddr(tblAddr), .tblWdata(tblWdata),
    .rxBitClk(rxBitClk), .rxFrameSync(rxFrameSync),
    .txBitClk(txBitClk), .txFrameSync(txFrameSync),
    .rxChan(rxChan), .txChan(txChan)
  );

  always #2 clk = ~clk;

  int nChecks = 0, nErrs = 0;
  bit finished = 0;
  logic [15:0] tbl [1024];
  int  startF [4];
  bit  fe [4], sl [4], crt [4], en [4];
  bit  started [8], pend [8];
  int  idx [8], expPrev [8];

  function automatic int chanOf(input int sel);
    case (sel)
      9: return 1; 10: return 2; 11: return 3; 12: return 4; 1: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] mk(input int sel, input int reps, input bit last);
    return 16'((sel << 5) | (reps << 2) | 2 | int'(last));
  endfunction

  function automatic int modelChan(input int l, input int bitIdx);
    int rem = bitIdx;
    for (int i = 0; i < 128; i++) begin
      int a = (l % 2) * 512 + ((startF[l / 2] * 32 + i) % 512);
      int e = int'(tbl[a]);
      int len = (((e >> 2) & 7) + 1) * 8;
      if (rem < len) return chanOf((e >> 5) & 15);
      rem -= len;
      if (e & 1) return 0;
    end
    return 0;
  endfunction

  function automatic int laneOut(input int l);
    int p = l / 2;
    return (l % 2) ? int'(rxChan[p*3 +: 3]) : int'(txChan[p*3 +: 3]);
  endfunction

  task automatic check(input int act, input int exp, input string tag, input int l);
    nChecks++;
    if (act != exp) begin
      nErrs++;
      $display("FAIL %s lane %0d: actual=%0d expected=%0d", tag, l, act, exp);
    end
  endtask

  task automatic wrReg(input int a, input int d);
    @(negedge clk); regWe = 1'b1; regAddr = 3'(a); regWdata = 16'(d);
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic wrTbl(input int a, input logic [15:0] d, input bit toModel);
    @(negedge clk); tblWe = 1'b1; tblAddr = 10'(a); tblWdata = d;
    @(negedge clk); tblWe = 1'b0;
    if (toModel) tbl[a] = d;
  endtask

  // R12: mode word of port p lives at address p
  task automatic setMode(input int p, input int s, input bit f, input bit low, input bit loop);
    startF[p] = s; fe[p] = f; sl[p] = low; crt[p] = loop;
    rxFrameSync[p] = low; txFrameSync[p] = low;
    wrReg(p, (s << 12) | (int'(loop) << 6) | (int'(low) << 5) | (int'(f) << 3) | 16'h0104);
  endtask

  // R6: enable word at address 4, bit p per port
  task automatic setEn(input int mask);
    wrReg(4, mask);
    for (int p = 0; p < 4; p++) begin
      en[p] = mask[p];
      if (!en[p]) begin
        started[2*p] = 0; started[2*p+1] = 0;
        pend[2*p] = 0; pend[2*p+1] = 0;
        expPrev[2*p] = 0; expPrev[2*p+1] = 0;
      end
    end
  endtask

  task automatic bitStep(input logic [3:0] syncMask, input bit txQuiet, input string tag);
    @(negedge clk);
    rxBitClk = '0;
    if (!txQuiet) txBitClk = '0;
    @(negedge clk); @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      rxFrameSync[p] = syncMask[p] ^ sl[p];
      txFrameSync[p] = txQuiet ? sl[p] : (syncMask[p] ^ sl[p]);
    end
    @(negedge clk);
    for (int l = 0; l < 8; l++) check(laneOut(l), expPrev[l], "R10 hold before rise", l);
    rxBitClk = '1;
    if (!txQuiet) txBitClk = '1;
    @(negedge clk); @(negedge clk);
    for (int l = 0; l < 8; l++) begin
      int p = l / 2;
      bit ticks = (l % 2 == 1) || !txQuiet || crt[p];
      if (en[p] && ticks) begin
        bit st = pend[l] || (syncMask[p] && fe[p]);
        pend[l] = syncMask[p] && !fe[p];
        if (st) begin started[l] = 1; idx[l] = 0; end
        expPrev[l] = started[l] ? modelChan(l, idx[l]) : 0;
        if (started[l]) idx[l]++;
      end
      check(laneOut(l), expPrev[l], tag, l);
    end
  endtask

  task automatic runBits(input int n, input logic [3:0] firstSync, input bit txQuiet,
                         input string tag);
    for (int b = 0; b < n; b++) bitStep(b == 0 ? firstSync : 4'h0, txQuiet, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    nErrs++; nChecks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 1024; i++) tbl[i] = 16'h0001;
    for (int l = 0; l < 8; l++) begin started[l] = 0; pend[l] = 0; idx[l] = 0; expPrev[l] = 0; end
    for (int p = 0; p < 4; p++) begin startF[p] = 0; fe[p] = 0; sl[p] = 0; crt[p] = 0; en[p] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int l = 0; l < 8; l++) check(laneOut(l), 0, "R5 reset output", l);

    // R5: untouched table yields unused for a whole frame
    setMode(0, 0, 1'b1, 1'b0, 1'b0);
    setEn(1);
    runBits(20, 4'h1, 1'b0, "R5 reset table");

    // Tables for port 0 (offset 32), 1 (256), 2 (64, no last), 3 (480, wraps)
    wrTbl(32, mk(9, 2, 0), 1); wrTbl(33, mk(1, 0, 0), 1); wrTbl(34, mk(13, 1, 0), 1);
    wrTbl(35, mk(12, 7, 0), 1); wrTbl(36, mk(11, 0, 1), 1);
    wrTbl(544, mk(10, 0, 0), 1); wrTbl(545, mk(12, 3, 1), 1);
    wrTbl(256, mk(11, 1, 0), 1); wrTbl(257, mk(0, 0, 0), 1); wrTbl(258, mk(10, 2, 1), 1);
    wrTbl(768, mk(1, 4, 1), 1);
    for (int i = 0; i < 128; i++) begin
      wrTbl(64 + i, mk((i % 2) ? 1 : 10, 0, 0), 1);
      wrTbl(576 + i, mk((i % 3 == 0) ? 12 : 9, 0, 0), 1);
    end
    for (int i = 0; i < 32; i++) begin
      wrTbl(480 + i, mk(10, 0, 0), 1);
      wrTbl(992 + i, mk(9, 0, 0), 1);
    end
    wrTbl(0, mk(11, 1, 1), 1);
    wrTbl(512, mk(12, 0, 1), 1);

    setMode(0, 1, 1'b1, 1'b0, 1'b0);
    setMode(1, 8, 1'b0, 1'b1, 1'b0);
    setMode(2, 2, 1'b1, 1'b0, 1'b1);
    setMode(3, 15, 1'b0, 1'b0, 1'b0);
    setEn(8'hFB);
    runBits(1040, 4'hF, 1'b0, "R1 R2 R3 R4 R6 R7 R8 R12 frame");

    // R9: transmit clocks idle, looped port still walks its transmit list
    setEn(8'h0F);
    runBits(1040, 4'hF, 1'b1, "R9 R4 loop and region end");

    // R11: rewrite the held word mid-frame
    runBits(10, 4'h1, 1'b0, "R11 before write");
    wrTbl(32, mk(12, 2, 0), 0);
    runBits(30, 4'h0, 1'b0, "R11 same frame");
    tbl[32] = mk(12, 2, 0);
    runBits(40, 4'h1, 1'b0, "R11 next frame");

    // R6: turn a port off mid-frame
    runBits(30, 4'hF, 1'b0, "R6 before disable");
    setEn(8'h0D);
    runBits(20, 4'h0, 1'b0, "R6 after disable");

    finish_run();
  end
endmodule